// File: doc/BRIEF.md
# Compare-Match Interval Timer

This block is a small memory-mapped timer for an interrupt-driven system. A 32-bit counter climbs from zero to a programmable wrap value and starts over. It advances only when a run field allows it, and then at a rate of one step per 2^p system clocks, where p is a programmable divider setting. One compare channel watches the count. When that channel is set to software-compare and the count lands on the channel's target, the channel raises a sticky event flag. Software clears the flag by writing a one to it. The flag also drives a level interrupt and a one-cycle pulse output.

Software reaches every register through a single-cycle bus. A write takes effect on the clock edge at which the write strobe is high. Read data is a combinational function of the address while the read strobe is high, and it reads as zero when the strobe is low. A typical driver does the following: it stops the counter, programs the wrap value, clears the count, arms the channel with a target, and then starts the counter. After each interrupt, the driver clears the flag and moves the target forward.

Top module: `cmp_timer`

## Requirements
- R1: After reset, every register reads 0 except the wrap register at 0x18, which reads 0xFFFFFFFF. The irq and match_pulse outputs are low.
- R2: The counter at 0x14 advances only while the run field (bits [4:3] of the control register at 0x10) equals 1. Values 0, 2 and 3 hold the count.
- R3: With divider field p (bits [2:0] at 0x10), the counter advances once per 2^p clocks. Writing 0x10 restarts the divider, so the count reads floor(n/2^p) n edges after the start write.
- R4: The counter steps from the wrap value at 0x18 to 0 and otherwise increments by one. A wrap value of 0 holds the count at 0.
- R5: Any write to 0x14 sets the count to 0, whatever the data. This write takes priority over an advance in the same cycle.
- R6: The channel mode field is bits [5:2] at 0x20. When it equals 4, an advance that brings the count equal to the target at 0x24 sets the flag (bit 0 at 0x1C) on that edge. match_pulse is high for exactly that one cycle. Other modes never set the flag.
- R7: Writing 1 to bit 0 at 0x1C clears the flag. Writing 0 leaves it unchanged. The flag otherwise stays set.
- R8: When a match and a clearing write occur in the same cycle, the flag ends up set.
- R9: irq is high while the flag and the channel interrupt enable (bit 6 at 0x20) are both 1.
- R10: Reads of 0x10 return only bits [4:0]. Reads of 0x20 return only bits [6:2]. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | DATA_W | Write data |
| bus_we | input | 1 | Write strobe, taken on the rising edge |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Combinational read data, zero when bus_re is low |
| irq | output | 1 | Level interrupt |
| match_pulse | output | 1 | One-cycle compare-match strobe |

## Verification
A start write counts as edge E0. The count is then floor(n/2^p) after edge En, because the divider restarts on that same edge. A match therefore shows up in the flag and on match_pulse at the first edge where the new count equals the target. For a target t with p=0, that is edge Et. match_pulse drops again at the edge after that. irq follows the flag with no added register.

The bench drives inputs and samples outputs on the falling edge. Register reads are combinational, so a read consumes no clock edge. Each expected value is tied to a counted number of rising edges after a known write, including the write that is made to land exactly on a match edge.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
    localparam int unsigned PS_W       = 3;
    localparam int unsigned MODE_W     = 4;
    localparam int unsigned OFS_CTRL   = 'h10;
    localparam int unsigned OFS_COUNT  = 'h14;
    localparam int unsigned OFS_WRAP   = 'h18;
    localparam int unsigned OFS_FLAGS  = 'h1C;
    localparam int unsigned OFS_CHCTL  = 'h20;
    localparam int unsigned OFS_CHVAL  = 'h24;
    localparam logic [1:0]        RUN_TICK  = 2'd1;
    localparam logic [MODE_W-1:0] CH_SWCMP  = 4'h4;

    typedef struct packed {
        logic [1:0]      run;
        logic [PS_W-1:0] ps;
    } tmr_ctrl_t;
endpackage

// File: rtl/cmp_timer_prescale.sv
module cmp_timer_prescale
    import cmp_timer_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ctrl_we,
    input  tmr_ctrl_t ctrl_wdata,
    output tmr_ctrl_t ctrl,
    output logic      tick
);
    localparam int unsigned DIV_W = (1 << PS_W) - 1;

    typedef struct packed {
        tmr_ctrl_t        ctrl;
        logic [DIV_W-1:0] div;
    } pre_state_t;

    pre_state_t st_d, st_q;
    logic [DIV_W-1:0] mask;

    always_comb begin
        mask = (DIV_W'(1) << st_q.ctrl.ps) - DIV_W'(1);
        tick = (st_q.ctrl.run == RUN_TICK) && ((st_q.div & mask) == mask);
        st_d = st_q;
        if (st_q.ctrl.run == RUN_TICK) st_d.div = st_q.div + DIV_W'(1);
        else                           st_d.div = '0;
        if (ctrl_we) begin
            st_d.ctrl = ctrl_wdata;
            st_d.div  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl = st_q.ctrl;

    // A divided rate never produces two ticks in a row
    assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && st_q.ctrl.ps != '0 && !ctrl_we) |=> !tick);
endmodule

// File: rtl/cmp_timer_counter.sv
module cmp_timer_counter #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clr,
    input  logic             wrap_we,
    input  logic [CNT_W-1:0] wrap_wdata,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] wrap,
    output logic             adv,
    output logic [CNT_W-1:0] cnt_next
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] wrap;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        adv      = tick && !clr;
        cnt_next = (st_q.cnt == st_q.wrap) ? '0 : st_q.cnt + CNT_W'(1);
        st_d     = st_q;
        if (clr)      st_d.cnt  = '0;
        else if (adv) st_d.cnt  = cnt_next;
        if (wrap_we)  st_d.wrap = wrap_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt  <= '0;
            st_q.wrap <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign count = st_q.cnt;
    assign wrap  = st_q.wrap;

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clr) |=> $stable(st_q.cnt));
    assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clr && st_q.cnt == st_q.wrap) |=> (st_q.cnt == '0));
    assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (st_q.cnt == '0));
endmodule

// File: rtl/cmp_timer_channel.sv
module cmp_timer_channel
    import cmp_timer_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic [CNT_W-1:0]  cnt_next,
    input  logic              ctl_we,
    input  logic [MODE_W-1:0] mode_wdata,
    input  logic              ie_wdata,
    input  logic              val_we,
    input  logic [CNT_W-1:0]  val_wdata,
    input  logic              clr_flag,
    output logic [MODE_W-1:0] mode,
    output logic              ie,
    output logic [CNT_W-1:0]  target,
    output logic              flag,
    output logic              irq,
    output logic              match_pulse
);
    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic              ie;
        logic [CNT_W-1:0]  target;
        logic              flag;
        logic              pulse;
    } ch_state_t;

    ch_state_t st_d, st_q;
    logic      match;

    always_comb begin
        match = adv && (st_q.mode == CH_SWCMP) && (cnt_next == st_q.target);
        st_d  = st_q;
        if (ctl_we) begin
            st_d.mode = mode_wdata;
            st_d.ie   = ie_wdata;
        end
        if (val_we)        st_d.target = val_wdata;
        if (match)         st_d.flag   = 1'b1;
        else if (clr_flag) st_d.flag   = 1'b0;
        st_d.pulse = match;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mode        = st_q.mode;
    assign ie          = st_q.ie;
    assign target      = st_q.target;
    assign flag        = st_q.flag;
    assign irq         = st_q.flag && st_q.ie;
    assign match_pulse = st_q.pulse;

    assert_match_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> (flag && match_pulse));
    assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr_flag) |=> flag);
    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (match && clr_flag) |=> flag);
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
    import cmp_timer_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              match_pulse
);
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(OFS_COUNT);
    localparam logic [ADDR_W-1:0] A_WRAP  = ADDR_W'(OFS_WRAP);
    localparam logic [ADDR_W-1:0] A_FLAGS = ADDR_W'(OFS_FLAGS);
    localparam logic [ADDR_W-1:0] A_CHCTL = ADDR_W'(OFS_CHCTL);
    localparam logic [ADDR_W-1:0] A_CHVAL = ADDR_W'(OFS_CHVAL);

    tmr_ctrl_t         ctrl, ctrl_wdata;
    logic              tick, adv;
    logic [DATA_W-1:0] count, wrap, cnt_next, target;
    logic [MODE_W-1:0] ch_mode;
    logic              ch_ie, ch_flag;

    assign ctrl_wdata = tmr_ctrl_t'(bus_wdata[$bits(tmr_ctrl_t)-1:0]);

    cmp_timer_prescale i_pre (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_we    (bus_we && bus_addr == A_CTRL),
        .ctrl_wdata (ctrl_wdata),
        .ctrl       (ctrl),
        .tick       (tick)
    );

    cmp_timer_counter #(.CNT_W(DATA_W)) i_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .clr        (bus_we && bus_addr == A_COUNT),
        .wrap_we    (bus_we && bus_addr == A_WRAP),
        .wrap_wdata (bus_wdata),
        .count      (count),
        .wrap       (wrap),
        .adv        (adv),
        .cnt_next   (cnt_next)
    );

    cmp_timer_channel #(.CNT_W(DATA_W)) i_ch (
        .clk         (clk),
        .rst_n       (rst_n),
        .adv         (adv),
        .cnt_next    (cnt_next),
        .ctl_we      (bus_we && bus_addr == A_CHCTL),
        .mode_wdata  (bus_wdata[MODE_W+1:2]),
        .ie_wdata    (bus_wdata[MODE_W+2]),
        .val_we      (bus_we && bus_addr == A_CHVAL),
        .val_wdata   (bus_wdata),
        .clr_flag    (bus_we && bus_addr == A_FLAGS && bus_wdata[0]),
        .mode        (ch_mode),
        .ie          (ch_ie),
        .target      (target),
        .flag        (ch_flag),
        .irq         (irq),
        .match_pulse (match_pulse)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_re) begin
            case (bus_addr)
                A_CTRL:  bus_rdata = DATA_W'(ctrl);
                A_COUNT: bus_rdata = count;
                A_WRAP:  bus_rdata = wrap;
                A_FLAGS: bus_rdata = DATA_W'(ch_flag);
                A_CHCTL: bus_rdata = DATA_W'({ch_ie, ch_mode, 2'b00});
                A_CHVAL: bus_rdata = target;
                default: bus_rdata = '0;
            endcase
        end
    end

    assert_idle_read_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_re |-> (bus_rdata == '0));
endmodule

// File: tb/test_cmp_timer.sv
module test_cmp_timer;
    localparam time CLK_P = 10ns;
    localparam logic [7:0] A_CTRL = 8'h10, A_COUNT = 8'h14, A_WRAP = 8'h18,
                           A_FLAGS = 8'h1C, A_CHCTL = 8'h20, A_CHVAL = 8'h24;

    typedef struct packed {
        logic [2:0]  ps;
        logic [31:0] wrapv;
        logic [15:0] edges;
        logic [31:0] exp;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{3'd0, 32'hFFFF_FFFF, 16'd5,  32'd5},
        '{3'd1, 32'hFFFF_FFFF, 16'd7,  32'd3},
        '{3'd3, 32'hFFFF_FFFF, 16'd16, 32'd2},
        '{3'd3, 32'hFFFF_FFFF, 16'd15, 32'd1},
        '{3'd2, 32'hFFFF_FFFF, 16'd3,  32'd0},
        '{3'd0, 32'd4,         16'd7,  32'd2},
        '{3'd1, 32'd2,         16'd12, 32'd0},
        '{3'd0, 32'd0,         16'd5,  32'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0, bus_re = 1'b0;
    logic [31:0] bus_rdata;
    logic        irq, match_pulse;
    int          checks = 0, errors = 0;
    bit          done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    cmp_timer i_cmp_timer (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .irq(irq), .match_pulse(match_pulse)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // called at a falling edge; write lands on the next rising edge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a; bus_re = 1'b1;
        #1;
        d = bus_rdata;
        bus_re = 1'b0;
    endtask

    initial begin
        #(CLK_P * 50000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, v2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(A_CTRL, v);  chk("R1 ctrl", v, 32'h0);
        rd(A_COUNT, v); chk("R1 count", v, 32'h0);
        rd(A_WRAP, v);  chk("R1 wrap", v, 32'hFFFF_FFFF);
        rd(A_FLAGS, v); chk("R1 flags", v, 32'h0);
        rd(A_CHCTL, v); chk("R1 chctl", v, 32'h0);
        rd(A_CHVAL, v); chk("R1 chval", v, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 pulse", {31'b0, match_pulse}, 32'h0);

        // R3 / R4 vector table: count after n edges from the start write
        foreach (VECS[i]) begin
            wr(A_CTRL, 32'h0);
            wr(A_WRAP, VECS[i].wrapv);
            wr(A_COUNT, 32'h0);
            wr(A_CTRL, 32'h08 | {29'b0, VECS[i].ps});
            repeat (int'(VECS[i].edges)) @(posedge clk);
            @(negedge clk);
            rd(A_COUNT, v);
            chk($sformatf("R3 R4 vector %0d", i), v, VECS[i].exp);
        end

        // R2 run field values other than 1 hold the count
        wr(A_WRAP, 32'hFFFF_FFFF);
        wr(A_CTRL, 32'h08);
        wr(A_CTRL, 32'h10);
        rd(A_COUNT, v);
        repeat (5) @(negedge clk);
        rd(A_COUNT, v2); chk("R2 run=2 holds", v2, v);
        wr(A_CTRL, 32'h00);
        rd(A_COUNT, v);
        repeat (5) @(negedge clk);
        rd(A_COUNT, v2); chk("R2 run=0 holds", v2, v);

        // R5 any counter write clears
        wr(A_COUNT, 32'h1234_5678);
        rd(A_COUNT, v); chk("R5 clear", v, 32'h0);

        // R10 readback masks
        wr(A_CTRL, 32'hFFFF_FFFF);
        rd(A_CTRL, v); chk("R10 ctrl mask", v, 32'h1F);
        wr(A_CHCTL, 32'hFFFF_FFFF);
        rd(A_CHCTL, v); chk("R10 chctl mask", v, 32'h7C);
        wr(A_CHCTL, 32'h0);
        wr(A_CTRL, 32'h0);

        // R6 compare in mode 4, interrupt disabled
        wr(A_COUNT, 32'h0);
        wr(A_CHVAL, 32'd5);
        wr(A_CHCTL, 32'h10);
        wr(A_CTRL, 32'h08);
        repeat (4) @(posedge clk);
        @(negedge clk);
        rd(A_FLAGS, v); chk("R6 no flag before match", v, 32'h0);
        chk("R6 no pulse before match", {31'b0, match_pulse}, 32'h0);
        @(posedge clk); @(negedge clk);
        rd(A_FLAGS, v); chk("R6 flag on match edge", v, 32'h1);
        chk("R6 pulse on match edge", {31'b0, match_pulse}, 32'h1);
        chk("R9 irq masked", {31'b0, irq}, 32'h0);
        @(posedge clk); @(negedge clk);
        chk("R6 pulse one cycle", {31'b0, match_pulse}, 32'h0);
        rd(A_FLAGS, v); chk("R7 flag sticky", v, 32'h1);

        // R9 enable raises irq; R7 write-0 keeps, write-1 clears
        wr(A_CHCTL, 32'h50);
        chk("R9 irq on", {31'b0, irq}, 32'h1);
        wr(A_FLAGS, 32'h0);
        rd(A_FLAGS, v); chk("R7 write 0 keeps", v, 32'h1);
        wr(A_FLAGS, 32'h1);
        rd(A_FLAGS, v); chk("R7 write 1 clears", v, 32'h0);
        chk("R9 irq off", {31'b0, irq}, 32'h0);

        // R6 disabled mode never sets the flag
        wr(A_CHCTL, 32'h40);
        wr(A_COUNT, 32'h0);
        repeat (10) @(negedge clk);
        rd(A_FLAGS, v); chk("R6 mode 0 no flag", v, 32'h0);
        chk("R6 mode 0 no irq", {31'b0, irq}, 32'h0);

        // R8 clearing write on a match edge: matches at E3, E7, E11
        wr(A_CTRL, 32'h0);
        wr(A_COUNT, 32'h0);
        wr(A_WRAP, 32'd3);
        wr(A_CHVAL, 32'd3);
        wr(A_CHCTL, 32'h50);
        wr(A_FLAGS, 32'h1);
        wr(A_CTRL, 32'h08);
        repeat (6) @(posedge clk);
        @(negedge clk);
        wr(A_FLAGS, 32'h1);
        rd(A_FLAGS, v); chk("R8 set wins", v, 32'h1);
        chk("R8 irq stays", {31'b0, irq}, 32'h1);
        wr(A_FLAGS, 32'h1);
        rd(A_FLAGS, v); chk("R7 clear off match", v, 32'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule